// File: doc/BRIEF.md
# A-then-B sequence trigger

This block turns two separate trigger events into one sequential trigger. Upstream detectors deliver event A and event B as single-cycle pulses. Event A arms the sequence. The final trigger fires on B, and only after a qualifying condition holds. That condition can be a programmable wait after A, a programmable number of B events, or both, with the wait applied first. The block never fires on A alone.

Software selects the mode, the delay (in clock cycles) and the B count, and then pulses the rearm input. The block waits for A and moves through its phases. It emits a one-cycle trigger and then holds until the next rearm. The delay and count values are captured at the moment A is accepted, so a reconfiguration partway through a sequence does not disturb it.

Mode encoding on `cfg_mode_i`:
- bit 0 set enables the delay phase. When it is clear, the delay is taken as zero.
- bit 1 set enables B counting. When it is clear, the first accepted B fires.

Top module: `seq_trig`

## Requirements
- R1: After reset the block is idle and `trig_o` is low. A and B events produce no trigger until `rearm_i` has been pulsed, and this also holds after a reset that arrives partway through a sequence.
- R2: A trigger needs a rearm, then an accepted A, then a later accepted B. B events that arrive without a prior A never fire. `trig_o` rises one cycle after the edge that sampled the final B.
- R3: `trig_o` is high for exactly one cycle per arming. After the trigger fires, further A and B events are ignored until the next rearm.
- R4: With delay D enabled (mode bit 0), B events sampled 1 to D cycles after the edge that accepted A are ignored. A B sampled D+1 or more cycles after A is accepted.
- R5: With counting enabled (mode bit 1) and count N, the trigger fires on the Nth accepted B after A. A count of 0 or 1 fires on the first accepted B, and a count of 255 fires on exactly the 255th.
- R6: With both bits set, B events during the delay are not counted, and the trigger fires on the Nth B after the delay ends.
- R7: While armed (in the delay or counting phase), further A events neither restart the delay nor reset the B count.
- R8: `rearm_i` in any state returns the block to waiting for A and discards delay and count progress. An A in the same cycle as `rearm_i` is ignored.
- R9: Delay and count are captured when A is accepted. Changes to `cfg_count_i` or `cfg_delay_i` after that have no effect on the running sequence.
- R10: A B sampled in the same cycle as the accepted A is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rearm_i | input | 1 | Start / rearm pulse |
| evt_a_i | input | 1 | Event A pulse (arms the sequence) |
| evt_b_i | input | 1 | Event B pulse (final-stage event) |
| cfg_mode_i | input | 2 | Bit 0 delay enable, bit 1 count enable |
| cfg_delay_i | input | DLY_W (24) | Delay after A, in clock cycles |
| cfg_count_i | input | CNT_W (8) | Number of B events that fire the trigger |
| trig_o | output | 1 | One-cycle final trigger |

## Verification
The bench targets the delay boundary. A design off by one cycle there would accept a B one cycle early or one cycle late, and the bench checks this with both a short and a 1000-cycle delay. It counts B events that land inside the delay, a same-cycle A and B, and a stray A while armed; a design that let any of these advance or restart the sequence would fire early or late. It also covers a rearm that collides with A, a count reconfigured partway through a sequence, the zero and maximum counts, and a reset that arrives while armed. Each of these would show up as a missing, premature or repeated trigger pulse.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT_A  = 3'd1,
        ST_DELAY   = 3'd2,
        ST_COUNT_B = 3'd3,
        ST_FIRED   = 3'd4
    } seq_state_e;

    localparam int MODE_W       = 2;
    localparam int MODE_DLY_BIT = 0;
    localparam int MODE_CNT_BIT = 1;

endpackage

// File: rtl/seq_trig_delay.sv
module seq_trig_delay #(
    parameter int DLY_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [DLY_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             expire_o
);

    localparam logic [DLY_W-1:0] DLY_ONE = {{(DLY_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DLY_W-1:0] rem;
    } dly_reg_t;

    dly_reg_t dly_d, dly_q;

    always_comb begin
        dly_d = dly_q;
        if (load_i) begin
            dly_d.rem = load_val_i;
        end else if (dec_i && (dly_q.rem != '0)) begin
            dly_d.rem = dly_q.rem - DLY_ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_q <= '0;
        else         dly_q <= dly_d;
    end

    assign expire_o = (dly_q.rem == DLY_ONE);

    // R4
    dly_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_i |-> (dly_q.rem != '0));

endmodule

// File: rtl/seq_trig_bcount.sv
module seq_trig_bcount #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] tgt_i,
    input  logic             evt_i,
    output logic             hit_o
);

    localparam logic [CNT_W:0]   CNT_ONE = {{CNT_W{1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] TGT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W:0]   cnt;
        logic [CNT_W-1:0] tgt;
    } bc_reg_t;

    bc_reg_t bc_d, bc_q;
    logic [CNT_W:0] cnt_next;

    assign cnt_next = bc_q.cnt + CNT_ONE;

    always_comb begin
        bc_d = bc_q;
        if (clr_i) begin
            bc_d.cnt = '0;
            bc_d.tgt = (tgt_i == '0) ? TGT_ONE : tgt_i;
        end else if (evt_i) begin
            bc_d.cnt = cnt_next;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bc_q <= '{cnt: '0, tgt: TGT_ONE};
        else         bc_q <= bc_d;
    end

    assign hit_o = evt_i && (cnt_next >= {1'b0, bc_q.tgt});

    // R5
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bc_q.cnt <= {1'b0, bc_q.tgt});

    // R5
    tgt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bc_q.tgt != '0);

endmodule

// File: rtl/seq_trig.sv
module seq_trig
    import seq_trig_pkg::*;
#(
    parameter int DLY_W = 24,
    parameter int CNT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rearm_i,
    input  logic              evt_a_i,
    input  logic              evt_b_i,
    input  logic [MODE_W-1:0] cfg_mode_i,
    input  logic [DLY_W-1:0]  cfg_delay_i,
    input  logic [CNT_W-1:0]  cfg_count_i,
    output logic              trig_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        seq_state_e st;
        logic       trig;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;

    logic [DLY_W-1:0] eff_delay;
    logic [CNT_W-1:0] eff_count;
    logic             dly_load, dly_dec, dly_expire;
    logic             b_clr, b_evt, b_hit;

    assign eff_delay = cfg_mode_i[MODE_DLY_BIT] ? cfg_delay_i : '0;
    assign eff_count = cfg_mode_i[MODE_CNT_BIT] ? cfg_count_i : CNT_ONE;

    always_comb begin
        seq_d      = seq_q;
        seq_d.trig = 1'b0;
        dly_load   = 1'b0;
        dly_dec    = 1'b0;
        b_clr      = 1'b0;
        b_evt      = 1'b0;
        if (rearm_i) begin
            seq_d.st = ST_WAIT_A;
        end else begin
            unique case (seq_q.st)
                ST_WAIT_A: begin
                    if (evt_a_i) begin
                        dly_load = 1'b1;
                        b_clr    = 1'b1;
                        seq_d.st = (eff_delay == '0) ? ST_COUNT_B : ST_DELAY;
                    end
                end
                ST_DELAY: begin
                    dly_dec = 1'b1;
                    if (dly_expire) seq_d.st = ST_COUNT_B;
                end
                ST_COUNT_B: begin
                    if (evt_b_i) begin
                        b_evt = 1'b1;
                        if (b_hit) begin
                            seq_d.st   = ST_FIRED;
                            seq_d.trig = 1'b1;
                        end
                    end
                end
                default: seq_d.st = seq_q.st;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '{st: ST_IDLE, trig: 1'b0};
        else         seq_q <= seq_d;
    end

    assign trig_o = seq_q.trig;

    seq_trig_delay #(.DLY_W(DLY_W)) u_delay (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (dly_load),
        .load_val_i (eff_delay),
        .dec_i      (dly_dec),
        .expire_o   (dly_expire)
    );

    seq_trig_bcount #(.CNT_W(CNT_W)) u_bcount (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (b_clr),
        .tgt_i  (eff_count),
        .evt_i  (b_evt),
        .hit_o  (b_hit)
    );

    // R3
    trig_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |=> !trig_o);

    // R2
    trig_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |-> $past(seq_q.st == ST_COUNT_B && evt_b_i && !rearm_i));

    // R8
    rearm_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rearm_i |=> (seq_q.st == ST_WAIT_A && !trig_o));

    // R7
    delay_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == ST_DELAY && !rearm_i && !dly_expire) |=> (seq_q.st == ST_DELAY));

    // R1
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == ST_IDLE && !rearm_i) |=> (seq_q.st == ST_IDLE && !trig_o));

endmodule

// File: tb/seq_trig_tb.sv
module seq_trig_tb;

    localparam int DLY_W = 24;
    localparam int CNT_W = 8;
    localparam int ROW_W = 26;
    localparam int NV    = 47;

    // row: {req[3:0], mode[1:0], delay[7:0], count[7:0], rearm, a, b, exp_trig}
    localparam logic [ROW_W-1:0] VEC [NV] = '{
        {4'd2, 2'd0, 8'd0, 8'd0, 4'b0010},   // R2 B while idle
        {4'd2, 2'd0, 8'd0, 8'd0, 4'b1000},   // R2 rearm
        {4'd2, 2'd0, 8'd0, 8'd0, 4'b0010},   // R2 B without A
        {4'd10, 2'd0, 8'd0, 8'd0, 4'b0110},  // R10 A and B together
        {4'd2, 2'd0, 8'd0, 8'd0, 4'b0011},   // R2 B after A fires
        {4'd3, 2'd0, 8'd0, 8'd0, 4'b0010},   // R3 no second pulse
        {4'd3, 2'd0, 8'd0, 8'd0, 4'b0100},   // R3 A ignored when fired
        {4'd3, 2'd0, 8'd0, 8'd0, 4'b0010},   // R3 B ignored when fired
        {4'd4, 2'd1, 8'd3, 8'd0, 4'b1000},   // R4 rearm, delay 3
        {4'd4, 2'd1, 8'd3, 8'd0, 4'b0100},   // R4 A
        {4'd4, 2'd1, 8'd3, 8'd0, 4'b0010},   // R4 B at +1 ignored
        {4'd4, 2'd1, 8'd3, 8'd0, 4'b0010},   // R4 B at +2 ignored
        {4'd4, 2'd1, 8'd3, 8'd0, 4'b0010},   // R4 B at +3 ignored
        {4'd4, 2'd1, 8'd3, 8'd0, 4'b0011},   // R4 B at +4 fires
        {4'd5, 2'd2, 8'd0, 8'd3, 4'b1000},   // R5 rearm, count 3
        {4'd5, 2'd2, 8'd0, 8'd3, 4'b0100},   // R5 A
        {4'd5, 2'd2, 8'd0, 8'd3, 4'b0010},   // R5 B1
        {4'd5, 2'd2, 8'd0, 8'd3, 4'b0000},   // R5 gap
        {4'd5, 2'd2, 8'd0, 8'd3, 4'b0010},   // R5 B2
        {4'd7, 2'd2, 8'd0, 8'd3, 4'b0100},   // R7 stray A keeps count
        {4'd5, 2'd2, 8'd0, 8'd3, 4'b0011},   // R5 B3 fires
        {4'd5, 2'd2, 8'd0, 8'd0, 4'b1000},   // R5 rearm, count 0
        {4'd5, 2'd2, 8'd0, 8'd0, 4'b0100},   // R5 A
        {4'd5, 2'd2, 8'd0, 8'd0, 4'b0011},   // R5 first B fires
        {4'd6, 2'd3, 8'd2, 8'd2, 4'b1000},   // R6 rearm, delay 2 count 2
        {4'd6, 2'd3, 8'd2, 8'd2, 4'b0100},   // R6 A
        {4'd6, 2'd3, 8'd2, 8'd2, 4'b0010},   // R6 B in delay not counted
        {4'd7, 2'd3, 8'd2, 8'd2, 4'b0100},   // R7 A in delay no restart
        {4'd6, 2'd3, 8'd2, 8'd2, 4'b0010},   // R6 B1 after delay
        {4'd6, 2'd3, 8'd2, 8'd2, 4'b0011},   // R6 B2 fires
        {4'd9, 2'd2, 8'd0, 8'd2, 4'b1000},   // R9 rearm, count 2
        {4'd9, 2'd2, 8'd0, 8'd2, 4'b0100},   // R9 A captures 2
        {4'd9, 2'd2, 8'd0, 8'd1, 4'b0010},   // R9 count changed, no fire
        {4'd9, 2'd2, 8'd0, 8'd1, 4'b0011},   // R9 fires on 2nd
        {4'd8, 2'd2, 8'd0, 8'd2, 4'b1000},   // R8 rearm, count 2
        {4'd8, 2'd2, 8'd0, 8'd2, 4'b0100},   // R8 A
        {4'd8, 2'd2, 8'd0, 8'd2, 4'b0010},   // R8 B1
        {4'd8, 2'd2, 8'd0, 8'd2, 4'b1000},   // R8 rearm discards progress
        {4'd8, 2'd2, 8'd0, 8'd2, 4'b0100},   // R8 A
        {4'd8, 2'd2, 8'd0, 8'd2, 4'b0010},   // R8 B1 again
        {4'd8, 2'd2, 8'd0, 8'd2, 4'b0011},   // R8 B2 fires
        {4'd8, 2'd2, 8'd0, 8'd2, 4'b1000},   // R8 rearm
        {4'd8, 2'd2, 8'd0, 8'd2, 4'b1100},   // R8 rearm with A, A ignored
        {4'd8, 2'd2, 8'd0, 8'd2, 4'b0010},   // R8 B still waiting for A
        {4'd8, 2'd2, 8'd0, 8'd2, 4'b0100},   // R8 A
        {4'd8, 2'd2, 8'd0, 8'd2, 4'b0010},   // R8 B1
        {4'd8, 2'd2, 8'd0, 8'd2, 4'b0011}    // R8 B2 fires
    };

    logic             clk;
    logic             rst_n;
    logic             rearm;
    logic             evt_a;
    logic             evt_b;
    logic [1:0]       mode;
    logic [DLY_W-1:0] dly;
    logic [CNT_W-1:0] cnt;
    logic             trig;

    int n_chk  = 0;
    int n_fail = 0;

    seq_trig #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .rearm_i     (rearm),
        .evt_a_i     (evt_a),
        .evt_b_i     (evt_b),
        .cfg_mode_i  (mode),
        .cfg_delay_i (dly),
        .cfg_count_i (cnt),
        .trig_o      (trig)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input int req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle at a falling edge, return at the next falling edge
    task automatic step(input logic r, input logic a, input logic b);
        rearm = r;
        evt_a = a;
        evt_b = b;
        @(negedge clk);
        rearm = 1'b0;
        evt_a = 1'b0;
        evt_b = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int first;
        rst_n = 1'b0;
        rearm = 1'b0;
        evt_a = 1'b0;
        evt_b = 1'b0;
        mode  = '0;
        dly   = '0;
        cnt   = '0;
        repeat (3) @(negedge clk);
        check(1, int'(trig), 0);          // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            mode = VEC[i][21:20];
            dly  = {{(DLY_W-8){1'b0}}, VEC[i][19:12]};
            cnt  = VEC[i][11:4];
            step(VEC[i][3], VEC[i][2], VEC[i][1]);
            check(int'(VEC[i][25:22]), int'(trig), int'(VEC[i][0]));
        end

        // R4 long delay: B every cycle, must fire exactly on step 1001
        mode = 2'd1;
        dly  = 24'd1000;
        cnt  = '0;
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        first = 0;
        for (int k = 1; k <= 1100; k++) begin
            step(1'b0, 1'b0, 1'b1);
            if (trig && first == 0) first = k;
        end
        check(4, first, 1001);

        // R5 maximum count 255
        mode = 2'd2;
        dly  = '0;
        cnt  = 8'd255;
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        first = 0;
        for (int k = 1; k <= 300; k++) begin
            step(1'b0, 1'b0, 1'b1);
            if (trig && first == 0) first = k;
        end
        check(5, first, 255);

        // R1 reset while armed: block must need a new rearm
        mode = 2'd0;
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(1, int'(trig), 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b1);
        check(1, int'(trig), 0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        check(1, int'(trig), 0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        check(2, int'(trig), 1);
        step(1'b0, 1'b0, 1'b0);
        check(3, int'(trig), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule